// File: doc/BRIEF.md
# I2C Bus Rate Prescaler with Divisor Search

This block derives the bit-timing strobe for an I2C master from the core clock. A 7-bit rate word carries a 4-bit linear factor M and a 3-bit exponent N. A linear counter divides the clock by M+1. A second counter divides that result by 2^(N+1). Each wrap of the second counter is one base tick. Ten base ticks form one SCL period, which gives f_scl = f_clk / (10 · (M+1) · 2^(N+1)).

A ten-step phase counter runs on the base ticks. It marks the low half and the high half of SCL, and it flags the tick on which the line level is due to change.

An optional search engine takes the core clock frequency and a requested bus frequency. It works through every (M, N) pair, one candidate for each completion of a serial divider. It returns the pair whose integer-rounded rate comes closest to the request without going over it, or it reports that no pair fits.

Top module: `i2c_baud_gen`

## Requirements
- R1: On a cycle with `rate_wr` high, the rate word is loaded from `rate_word`, with M taken from bits [6:3] and N taken from bits [2:0].
- R2: Base ticks (`tick` high for one cycle) repeat every (M+1)·2^(N+1) clock cycles.
- R3: A rate write clears both divider stages and the phase counter. The first tick appears in the (M+1)·2^(N+1)-th cycle after the write edge. This also holds when the write falls in the same cycle as a tick, in which case the write takes precedence over the phase advance.
- R4: Counting ticks after a restart, `scl_hi` is 0 while ticks 1 to 5 are seen and 1 while ticks 6 to 10 are seen. The pattern then repeats, and `scl_hi` changes only on the edge that follows a tick or a write.
- R5: `scl_edge` is high only together with `tick`, and only on the 5th and 10th tick of each SCL period.
- R6: After reset, `tick`, `scl_hi`, `scl_edge`, `srch_busy`, `srch_done` and `srch_ok` are 0, and the rate word is M=0, N=0, so ticks come every 2 cycles.
- R7: The search evaluates floor(f_clk / (10·(M+1)·2^(N+1))) for every pair. It returns the pair whose value is at or below the request and whose shortfall is smallest, and it sets `srch_ok`.
- R8: Candidates are visited with N as the outer loop (0 to 7) and M as the inner loop (0 to 15). Only a strictly smaller shortfall replaces the best pair, so on a tie the earliest pair is kept.
- R9: When every candidate rate exceeds the request, `srch_ok` is 0 and `srch_m` and `srch_n` are 0.
- R10: `srch_busy` rises on the edge that samples `srch_start`. `srch_done` is a one-cycle pulse on the edge where busy falls, and the result holds until the next search ends. A start while busy is ignored, and the operands are latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_wr | input | 1 | Rate word write strobe |
| rate_word | input | 7 | M in [6:3], N in [2:0] |
| tick | output | 1 | Base tick, ten per SCL period |
| scl_hi | output | 1 | SCL phase: 0 low half, 1 high half |
| scl_edge | output | 1 | Tick on which SCL level changes |
| srch_start | input | 1 | Start a divisor search |
| srch_clk_hz | input | 32 | Core clock frequency in Hz |
| srch_req_hz | input | 32 | Requested SCL frequency in Hz |
| srch_busy | output | 1 | Search in progress |
| srch_done | output | 1 | One-cycle search completion pulse |
| srch_ok | output | 1 | A pair at or below the request was found |
| srch_m | output | 4 | Chosen linear factor |
| srch_n | output | 3 | Chosen exponent |

## Verification
A rate write can arrive in the same cycle as a base tick. In that cycle the divider restart and the phase advance compete for the phase counter. The bench waits until it sees a tick, raises the write in that same cycle with a new rate word, and then times the first tick at the new period. It then checks that the next ten ticks show five low and five high phases starting from phase zero; a phase advanced by the stale tick would shift that pattern by one. In a second overlap, a new start arrives in the middle of a search with different operands, and the bench checks that the result still belongs to the first request.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;
  localparam int M_W        = 4;
  localparam int N_W        = 3;
  localparam int RATE_W     = M_W + N_W;
  localparam int HZ_W       = 32;
  localparam int BASE_DIV   = 10;
  localparam int HALF_TICKS = BASE_DIV / 2;
  localparam int POW_W      = 1 << N_W;
  localparam int DEN_W      = 4 + M_W + POW_W;
  localparam int PH_W       = $clog2(BASE_DIV);
  localparam int PER_W      = M_W + 1 + POW_W;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } rate_t;

  // terminal count of the power-of-two stage: 2^(n+1) - 1
  function automatic logic [POW_W-1:0] pow_limit(input logic [N_W-1:0] n);
    logic [POW_W:0] span;
    span = (POW_W+1)'(1) << ({1'b0, n} + (N_W+1)'(1));
    return POW_W'(span - (POW_W+1)'(1));
  endfunction

  // full divisor of one candidate: 10 * (m+1) * 2^(n+1)
  function automatic logic [DEN_W-1:0] cand_den(input logic [M_W-1:0] m,
                                                 input logic [N_W-1:0] n);
    logic [DEN_W-1:0] lin;
    lin = (DEN_W'(m) + DEN_W'(1)) * DEN_W'(BASE_DIV);
    return lin << ({1'b0, n} + (N_W+1)'(1));
  endfunction
endpackage

// File: rtl/stage_counter.sv
module stage_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = en && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/serial_div.sv
module serial_div #(
  parameter int NW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic          busy_q;
  logic [CW-1:0] step_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] dvs_q;
  logic [NW-1:0] quo_q;
  logic [DW:0]   shifted;
  logic          fits;
  logic [DW:0]   diff;

  assign shifted = {rem_q, quo_q[NW-1]};
  assign fits    = shifted >= {1'b0, dvs_q};
  assign diff    = shifted - {1'b0, dvs_q};
  assign quot    = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done   <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy_q) begin
        busy_q <= 1'b1;
        step_q <= '0;
        rem_q  <= '0;
        dvs_q  <= divisor;
        quo_q  <= dividend;
      end else if (busy_q) begin
        rem_q  <= fits ? diff[DW-1:0] : shifted[DW-1:0];
        quo_q  <= {quo_q[NW-2:0], fits};
        step_q <= step_q + CW'(1);
        if (step_q == CW'(NW - 1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baud_search.sv
module baud_search
  import i2c_baud_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [HZ_W-1:0] clk_hz,
  input  logic [HZ_W-1:0] req_hz,
  output logic            busy,
  output logic            done,
  output logic            ok,
  output logic [M_W-1:0]  m_out,
  output logic [N_W-1:0]  n_out
);
  localparam logic [M_W-1:0] M_LAST = '1;
  localparam logic [N_W-1:0] N_LAST = '1;

  logic [HZ_W-1:0] clk_q, req_q, best_d;
  logic [M_W-1:0]  m_c, best_m;
  logic [N_W-1:0]  n_c, best_n;
  logic            found_q, launch_q;
  logic            div_done;
  logic [HZ_W-1:0] cand_hz;
  logic [HZ_W-1:0] shortfall;
  logic            take, last_cand, found_nx;

  serial_div #(.NW(HZ_W), .DW(DEN_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (launch_q),
    .dividend (clk_q),
    .divisor  (cand_den(m_c, n_c)),
    .done     (div_done),
    .quot     (cand_hz)
  );

  assign shortfall = req_q - cand_hz;
  assign take      = (cand_hz <= req_q) && (!found_q || (shortfall < best_d));
  assign last_cand = (m_c == M_LAST) && (n_c == N_LAST);
  assign found_nx  = found_q || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      m_out    <= '0;
      n_out    <= '0;
      clk_q    <= '0;
      req_q    <= '0;
      best_d   <= '0;
      best_m   <= '0;
      best_n   <= '0;
      m_c      <= '0;
      n_c      <= '0;
      found_q  <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      done     <= 1'b0;
      launch_q <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        clk_q    <= clk_hz;
        req_q    <= req_hz;
        m_c      <= '0;
        n_c      <= '0;
        found_q  <= 1'b0;
        best_d   <= '0;
        best_m   <= '0;
        best_n   <= '0;
        launch_q <= 1'b1;
      end else if (busy && div_done) begin
        if (take) begin
          best_d  <= shortfall;
          best_m  <= m_c;
          best_n  <= n_c;
        end
        found_q <= found_nx;
        if (last_cand) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          ok    <= found_nx;
          m_out <= found_nx ? (take ? m_c : best_m) : '0;
          n_out <= found_nx ? (take ? n_c : best_n) : '0;
        end else begin
          if (m_c == M_LAST) begin
            m_c <= '0;
            n_c <= n_c + N_W'(1);
          end else begin
            m_c <= m_c + M_W'(1);
          end
          launch_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen
  import i2c_baud_pkg::*;
#(
  parameter bit HAS_SEARCH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_word,
  output logic              tick,
  output logic              scl_hi,
  output logic              scl_edge,
  input  logic              srch_start,
  input  logic [HZ_W-1:0]   srch_clk_hz,
  input  logic [HZ_W-1:0]   srch_req_hz,
  output logic              srch_busy,
  output logic              srch_done,
  output logic              srch_ok,
  output logic [M_W-1:0]    srch_m,
  output logic [N_W-1:0]    srch_n
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BASE_DIV - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(HALF_TICKS - 1);

  rate_t           rate_q;
  logic            lin_wrap;
  logic            pow_wrap;
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_wr) rate_q <= rate_t'(rate_word);
  end

  stage_counter #(.W(M_W)) u_lin (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rate_wr),
    .en    (1'b1),
    .lim   (rate_q.m),
    .wrap  (lin_wrap)
  );

  stage_counter #(.W(POW_W)) u_pow (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rate_wr),
    .en    (lin_wrap),
    .lim   (pow_limit(rate_q.n)),
    .wrap  (pow_wrap)
  );

  assign tick = pow_wrap;

  // the restart takes precedence over the tick when both land together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ph_q <= '0;
    else if (rate_wr)  ph_q <= '0;
    else if (tick)     ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
  end

  assign scl_hi   = ph_q >= PH_W'(HALF_TICKS);
  assign scl_edge = tick && ((ph_q == PH_MID) || (ph_q == PH_LAST));

  generate
    if (HAS_SEARCH) begin : g_search
      baud_search u_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (srch_start),
        .clk_hz (srch_clk_hz),
        .req_hz (srch_req_hz),
        .busy   (srch_busy),
        .done   (srch_done),
        .ok     (srch_ok),
        .m_out  (srch_m),
        .n_out  (srch_n)
      );
    end else begin : g_no_search
      logic unused_in;
      assign unused_in = srch_start ^ (^srch_clk_hz) ^ (^srch_req_hz);
      assign srch_busy = 1'b0;
      assign srch_done = 1'b0;
      assign srch_ok   = 1'b0;
      assign srch_m    = '0;
      assign srch_n    = '0;
    end
  endgenerate
endmodule

// File: rtl/i2c_baud_gen_chk.sv
module i2c_baud_gen_chk
  import i2c_baud_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rate_wr,
  input logic [RATE_W-1:0] rate_word,
  input logic              tick,
  input logic              scl_hi,
  input logic              scl_edge,
  input logic              srch_busy,
  input logic              srch_done,
  input logic              srch_ok,
  input logic [M_W-1:0]    srch_m,
  input logic [N_W-1:0]    srch_n
);
  logic [RATE_W-1:0] seen_word;
  logic [PER_W-1:0]  since_q;
  logic [PER_W-1:0]  want_per;

  // period recomputed from the port-level word as a product of two terms
  assign want_per = PER_W'(({1'b0, seen_word[RATE_W-1:N_W]} + (M_W+1)'(1)))
                    * (PER_W'(2) << seen_word[N_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_word <= '0;
      since_q   <= '0;
    end else begin
      if (rate_wr) seen_word <= rate_word;
      if (rate_wr || tick) since_q <= '0;
      else                 since_q <= since_q + PER_W'(1);
    end
  end

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (since_q == want_per - PER_W'(1)));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(rate_wr)) |-> $stable(scl_hi));

  // R5
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_edge |-> tick);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |=> !srch_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> !srch_busy);

  // R9
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && !srch_ok) |-> (srch_m == '0 && srch_n == '0));
endmodule

bind i2c_baud_gen i2c_baud_gen_chk u_chk (.*);

// File: tb/sim_i2c_baud_gen.sv
module sim_i2c_baud_gen;
  import i2c_baud_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rate_wr = 1'b0;
  logic [RATE_W-1:0] rate_word = '0;
  logic              srch_start = 1'b0;
  logic [HZ_W-1:0]   srch_clk_hz = '0;
  logic [HZ_W-1:0]   srch_req_hz = '0;
  logic              tick, scl_hi, scl_edge;
  logic              srch_busy, srch_done, srch_ok;
  logic [M_W-1:0]    srch_m;
  logic [N_W-1:0]    srch_n;

  i2c_baud_gen u0 (.*);

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // rate vectors: {M, N (4 bits), expected tick period}
  localparam logic [23:0] PVEC [6] = '{
    {4'd0,  4'd0, 16'd2},    {4'd3, 4'd1, 16'd16},
    {4'd15, 4'd0, 16'd32},   {4'd2, 4'd2, 16'd24},
    {4'd0,  4'd7, 16'd256},  {4'd15, 4'd7, 16'd4096}
  };
  // search vectors: {core clock Hz, requested Hz}
  localparam logic [63:0] SVEC [5] = '{
    {32'd100_000_000, 32'd100_000},
    {32'd166_000_000, 32'd400_000},
    {32'd25_000_000,  32'd1_000_000_000},
    {32'd4000,        32'd100},
    {32'd1_000_000,   32'd10}
  };

  task automatic check(input bit good, input string tag,
                       input longint act, input longint exp);
    n_vec++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_search(input longint ck, input longint rq,
                                       output bit ok, output int bm, output int bn);
    longint best;
    best = -1; ok = 0; bm = 0; bn = 0;
    for (int n = 0; n < 8; n++)
      for (int m = 0; m < 16; m++) begin
        longint f;
        f = ck / (longint'(m + 1) * 10 * (longint'(1) << (n + 1)));
        if (f <= rq && (best < 0 || (rq - f) < best)) begin
          best = rq - f; ok = 1; bm = m; bn = n;
        end
      end
  endfunction

  task automatic write_rate(input int m, input int n);
    rate_wr   = 1'b1;
    rate_word = {4'(m), 3'(n)};
    @(negedge clk);
    rate_wr   = 1'b0;
  endtask

  task automatic wait_tick(output int k);
    k = 1;
    while (!tick && k < 10000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_search(input longint ck, input longint rq, input bit poke,
                            output bit ok, output int m, output int n);
    int k;
    srch_clk_hz = 32'(ck);
    srch_req_hz = 32'(rq);
    srch_start  = 1'b1;
    @(negedge clk);
    srch_start  = 1'b0;
    check(srch_busy == 1'b1, "R10 busy after start", srch_busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      srch_clk_hz = 32'd50_000_000;
      srch_req_hz = 32'd1;
      srch_start  = 1'b1;
      @(negedge clk);
      srch_start  = 1'b0;
    end
    k = 0;
    while (!srch_done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(srch_done == 1'b1, "R10 done seen", srch_done, 1);
    check(srch_busy == 1'b0, "R10 busy low with done", srch_busy, 0);
    ok = srch_ok; m = srch_m; n = srch_n;
    @(negedge clk);
    check(srch_done == 1'b0, "R10 done one cycle", srch_done, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int k;
    bit eok, gok;
    int em, en, gm, gn;

    // R6 reset state
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R6 tick in reset", tick, 0);
    check(scl_hi == 1'b0, "R6 scl_hi in reset", scl_hi, 0);
    check(scl_edge == 1'b0, "R6 scl_edge in reset", scl_edge, 0);
    check(srch_busy == 1'b0, "R6 busy in reset", srch_busy, 0);
    check(srch_done == 1'b0, "R6 done in reset", srch_done, 0);
    check(srch_ok == 1'b0, "R6 ok in reset", srch_ok, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wait_tick(k);
    @(negedge clk);
    wait_tick(k);
    check(k == 2, "R6 default tick period", k, 2);

    // R1 R2 R3 table of rate words
    foreach (PVEC[i]) begin
      int pm, pn, per;
      pm  = int'(PVEC[i][23:20]);
      pn  = int'(PVEC[i][19:16]);
      per = int'(PVEC[i][15:0]);
      write_rate(pm, pn);
      wait_tick(k);
      check(k == per, $sformatf("R3 first tick m=%0d n=%0d", pm, pn), k, per);
      @(negedge clk);
      wait_tick(k);
      check(k == per, $sformatf("R2 R1 period m=%0d n=%0d", pm, pn), k, per);
    end

    // R3 write colliding with a tick, then R4 R5 phase pattern
    write_rate(3, 1);
    wait_tick(k);
    write_rate(1, 0);
    wait_tick(k);
    check(k == 4, "R3 first tick after colliding write", k, 4);
    for (int t = 1; t <= 10; t++) begin
      check(scl_hi == (t > 5), $sformatf("R4 scl_hi at tick %0d", t), scl_hi, (t > 5));
      check(scl_edge == (t == 5 || t == 10),
            $sformatf("R5 scl_edge at tick %0d", t), scl_edge, (t == 5 || t == 10));
      @(negedge clk);
      check(scl_edge == 1'b0, "R5 scl_edge off tick", scl_edge, 0);
      if (t < 10) wait_tick(k);
    end

    // R7 R8 R9 search table
    foreach (SVEC[i]) begin
      longint ck, rq;
      ck = longint'(SVEC[i][63:32]);
      rq = longint'(SVEC[i][31:0]);
      model_search(ck, rq, eok, em, en);
      run_search(ck, rq, 1'b0, gok, gm, gn);
      check(gok == eok, $sformatf("R7 ok clk=%0d req=%0d", ck, rq), gok, eok);
      check(gm == em, $sformatf("R7 M clk=%0d req=%0d", ck, rq), gm, em);
      check(gn == en, $sformatf("R7 N clk=%0d req=%0d", ck, rq), gn, en);
      if (ck == 4000) begin
        check(gm == 1 && gn == 0, "R8 tie keeps first pair M", gm, 1);
        check(gn == 0, "R8 tie keeps first pair N", gn, 0);
      end
      if (ck == 1_000_000) begin
        check(gok == 1'b0, "R9 no fit ok", gok, 0);
        check(gm == 0 && gn == 0, "R9 no fit zero M N", gm * 8 + gn, 0);
      end
    end

    // R10 start during a search is ignored
    model_search(100_000_000, 100_000, eok, em, en);
    run_search(100_000_000, 100_000, 1'b1, gok, gm, gn);
    check(gm == em && gn == en && gok == eok, "R10 second start ignored",
          gm * 8 + gn, em * 8 + en);

    finish_run();
  end
endmodule